// File: doc/BRIEF.md
# Skip-Value Modulo Sequence Counter

This block is a free-running synchronous counter whose sequence departs from plain binary in two places. In its default mode it climbs from 0 to 32, never shows the value 13 (the step after 12 lands on 14), and then returns to 0 to start again. A second mode moves the final value to 63, so the counter spans the whole 6-bit range. The value 13 is still omitted in that mode.

The counter is built from two cascaded 4-bit synchronous counter cells. Each cell has a synchronous clear, a synchronous parallel load, two count enables and a carry output. A small decode stage watches the combined count and asks the cells for a synchronous load of 14 or a synchronous clear at the next rising edge. Every change of state happens on that edge, so the output never shows a short-lived decoded value. An enable input freezes the sequence, and a synchronous active-high reset returns it to 0.

Top module: `skip_seq_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is 0 after that edge, whatever the values of `en` and `mode_long`.
- R2: When `en` is high at a rising edge and the count is below the final value and is not 12, the count rises by exactly one.
- R3: The value 13 never appears on `count` after reset. In both modes, an enabled edge at count 12 gives 14.
- R4: With `mode_long` low, the final value is 32. An enabled edge at 32 gives 0.
- R5: With `mode_long` high, the final value is 63. An enabled edge at 63 gives 0.
- R6: When `en` is low and `rst` is low at a rising edge, `count` keeps its value.
- R7: If `count` is above the final value of the current mode (after `mode_long` falls while the count is between 33 and 63), the next enabled edge gives 0.
- R8: Starting from 0 and with `en` held high, the count is 0 again after exactly 32 edges in the default mode and after exactly 63 edges in the long mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable. When low, the count holds |
| mode_long | input | 1 | 0: final value 32. 1: final value 63 |
| count | output | 6 | Registered count value |

## Verification
Two full default-mode periods are run with `en` held high, and every transition is compared with a reference model. This shows apart an off-by-one wrap point, a missing skip, and a skip that lands on the wrong value. A full long-mode period checks that the wrap point moves to 63 and that the skip at 12 is still applied. A pattern that switches `en` on and off on alternate edges, including at 12 and at 32, shows whether the load and the clear are gated by the enable. A mode drop while the count is above 32, and a reset that arrives while `en` is low in the middle of a run, test the recovery paths.

// File: rtl/skip_cnt_pkg.sv
package skip_cnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } step_act_e;
endpackage

// File: rtl/skip_cnt_cell.sv
module skip_cnt_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  // clear wins over load, and load wins over counting
  always_ff @(posedge clk) begin
    if (clr)                q <= '0;
    else if (ld)            q <= din;
    else if (en_p && en_t)  q <= q + W'(1);
  end

  assign carry = en_t && (&q);
endmodule

// File: rtl/skip_cnt_decode.sv
module skip_cnt_decode
  import skip_cnt_pkg::*;
#(
  parameter int TOT_W      = 8,
  parameter int SKIP_VAL   = 13,
  parameter int LAST_SHORT = 32,
  parameter int LAST_LONG  = 63
) (
  input  logic             rst,
  input  logic             en,
  input  logic             mode_long,
  input  logic [TOT_W-1:0] cur,
  output step_act_e        act,
  output logic [TOT_W-1:0] load_val
);
  localparam logic [TOT_W-1:0] PRE_SKIP = TOT_W'(SKIP_VAL - 1);
  localparam logic [TOT_W-1:0] POST_SKIP = TOT_W'(SKIP_VAL + 1);

  logic [TOT_W-1:0] last_val;

  always_comb begin
    last_val = mode_long ? TOT_W'(LAST_LONG) : TOT_W'(LAST_SHORT);
    load_val = POST_SKIP;
    if (rst)                   act = ACT_CLEAR;
    else if (!en)              act = ACT_HOLD;
    else if (cur >= last_val)  act = ACT_CLEAR;
    else if (cur == PRE_SKIP)  act = ACT_LOAD;
    else                       act = ACT_STEP;
  end
endmodule

// File: rtl/skip_seq_counter.sv
module skip_seq_counter
  import skip_cnt_pkg::*;
#(
  parameter int CELL_W     = 4,
  parameter int N_CELLS    = 2,
  parameter int OUT_W      = 6,
  parameter int SKIP_VAL   = 13,
  parameter int LAST_SHORT = 32,
  parameter int LAST_LONG  = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_long,
  output logic [OUT_W-1:0] count
);
  localparam int TOT_W = CELL_W * N_CELLS;

  logic [TOT_W-1:0] cur;
  logic [TOT_W-1:0] load_val;
  logic [N_CELLS:0] chain;
  step_act_e        act;
  logic             clr_all, ld_all, cnt_en;

  skip_cnt_decode #(
    .TOT_W(TOT_W), .SKIP_VAL(SKIP_VAL),
    .LAST_SHORT(LAST_SHORT), .LAST_LONG(LAST_LONG)
  ) u_dec (
    .rst(rst), .en(en), .mode_long(mode_long), .cur(cur),
    .act(act), .load_val(load_val)
  );

  assign clr_all  = (act == ACT_CLEAR);
  assign ld_all   = (act == ACT_LOAD);
  assign cnt_en   = (act == ACT_STEP);
  assign chain[0] = cnt_en;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    skip_cnt_cell #(.W(CELL_W)) u_cell (
      .clk  (clk),
      .clr  (clr_all),
      .ld   (ld_all),
      .en_p (cnt_en),
      .en_t (chain[i]),
      .din  (load_val[i*CELL_W +: CELL_W]),
      .q    (cur[i*CELL_W +: CELL_W]),
      .carry(chain[i+1])
    );
  end

  assign count = cur[OUT_W-1:0];
endmodule

// File: rtl/skip_cnt_chk.sv
module skip_cnt_chk #(
  parameter int OUT_W      = 6,
  parameter int SKIP_VAL   = 13,
  parameter int LAST_SHORT = 32,
  parameter int LAST_LONG  = 63
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             mode_long,
  input logic [OUT_W-1:0] count
);
  logic [OUT_W-1:0] last_v;
  logic             past_rst;
  logic             seen_rst;

  assign last_v = mode_long ? OUT_W'(LAST_LONG) : OUT_W'(LAST_SHORT);

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (past_rst === 1'b1)
      assert_reset_zero_R1: assert (count == '0);
  end

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (en && count != OUT_W'(SKIP_VAL - 1) && count < last_v)
      |=> count == $past(count) + OUT_W'(1));

  assert_never_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1) |-> count != OUT_W'(SKIP_VAL));

  assert_jump_over_R3: assert property (@(posedge clk) disable iff (rst)
    (en && count == OUT_W'(SKIP_VAL - 1)) |=> count == OUT_W'(SKIP_VAL + 1));

  assert_short_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !mode_long && count == OUT_W'(LAST_SHORT)) |=> count == '0);

  assert_long_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (en && mode_long && count == OUT_W'(LAST_LONG)) |=> count == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (en && count > last_v) |=> count == '0);
endmodule

bind skip_seq_counter skip_cnt_chk #(
  .OUT_W(OUT_W), .SKIP_VAL(SKIP_VAL),
  .LAST_SHORT(LAST_SHORT), .LAST_LONG(LAST_LONG)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .mode_long(mode_long), .count(count)
);

// File: tb/sim_skip_seq_counter.sv
module sim_skip_seq_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode_long = 1'b0;
  logic [5:0] count;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  skip_seq_counter u0 (
    .clk(clk), .rst(rst), .en(en), .mode_long(mode_long), .count(count)
  );

  function automatic logic [5:0] model(logic [5:0] c, logic m, logic e);
    logic [5:0] last;
    last = m ? 6'd63 : 6'd32;
    if (!e)            return c;
    if (c >= last)     return 6'd0;
    if (c == 6'd12)    return 6'd14;
    return c + 6'd1;
  endfunction

  task automatic check(string req, logic [5:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; mode_long = 1'b0;
    tick();
    check("R1", 6'd0);
    rst = 1'b0;
  endtask

  task automatic run_period(logic m, int steps, string req);
    logic [5:0] exp;
    mode_long = m; en = 1'b1;
    exp = count;
    for (int i = 0; i < steps; i++) begin
      exp = model(exp, m, 1'b1);
      tick();
      check(req, exp);
      if (count == 6'd13) check("R3", 6'd14);
    end
  endtask

  task automatic t_default_two_periods();
    run_period(1'b0, 32, "R2/R4");
    check("R8", 6'd0);
    run_period(1'b0, 32, "R2/R4");
    check("R8", 6'd0);
  endtask

  task automatic t_long_period();
    run_period(1'b1, 63, "R5/R3");
    check("R8", 6'd0);
  endtask

  task automatic t_hold();
    logic [5:0] exp;
    mode_long = 1'b0;
    exp = count;
    for (int i = 0; i < 90; i++) begin
      en = i[0];
      exp = model(exp, 1'b0, en);
      tick();
      check(en ? "R2/R3/R4" : "R6", exp);
    end
    en = 1'b0;
  endtask

  task automatic t_overrun();
    t_reset();
    en = 1'b1; mode_long = 1'b1;
    for (int i = 0; i < 39; i++) tick();
    check("R5", 6'd40);
    mode_long = 1'b0; en = 1'b0;
    tick();
    check("R6", 6'd40);
    en = 1'b1;
    tick();
    check("R7", 6'd0);
  endtask

  task automatic t_mid_reset();
    en = 1'b1; mode_long = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    check("R2", 6'd21);
    en = 1'b0; rst = 1'b1;
    tick();
    check("R1", 6'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: count=%0d expected=done", count);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_default_two_periods();
    t_long_period();
    t_hold();
    t_overrun();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule